// File: doc/BRIEF.md
# BCD Accumulator Decimal Adjust Unit

This unit fixes up an 8-bit accumulator after two packed-BCD bytes have been added in binary. It takes the accumulator together with the carry and half-carry flags from that addition. From these it picks a correction of 0x00, 0x06, 0x60 or 0x66. It adds the correction through its own 8-bit adder and returns the corrected byte with a fresh set of flags: sign, zero, parity, half-carry and carry. Fix-up after subtraction is not handled.

Operands enter on a valid/ready stream and leave on a second valid/ready stream, with one register stage between them. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. The result appears on the next cycle. While a result is held because the consumer keeps `out_ready` low, `in_ready` stays low and nothing new is taken. When `out_ready` is high, a new operand can be taken on the same edge that drains the old result, so back-to-back operands flow at one per cycle.

Top module: `decadj_unit`

## Requirements
- R1: The low correction 0x06 is part of the correction whenever the incoming half-carry is 1 or the low nibble (bits 3:0) of the accumulator is greater than 9.
- R2: The high correction 0x60 is part of the correction whenever the incoming carry is 1, or the high nibble (bits 7:4) is greater than 9, or the high nibble is 9 or more while the low nibble is greater than 9.
- R3: `out_acc` equals the incoming accumulator plus the correction, modulo 256.
- R4: `out_cy` is 1 when the high correction applied, and otherwise equals the incoming carry, so an incoming carry of 1 always gives 1.
- R5: `out_sign` equals bit 7 of `out_acc`, and `out_zero` is 1 exactly when `out_acc` is 0x00.
- R6: `out_par` is 1 when `out_acc` has an even number of 1 bits.
- R7: `out_ac` is the carry out of bit 3 in the correction addition. It is taken from bit 3 of the accumulator, of the correction and of the sum, which together form an index (accumulator bit as MSB). The flag is 1 for index 2, 4, 6 or 7.
- R8: An operand taken on an edge gives `out_valid` high in the following cycle. `in_ready` is high whenever no result is pending or `out_ready` is high. With no new operand taken, a result drained with `out_ready` leaves `out_valid` low.
- R9: While `out_valid` is high and `out_ready` is low, `in_ready` is low. The result and all flags stay unchanged, and operands offered in that time are ignored.
- R10: During reset `out_valid` is 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit can take an operand on this edge |
| in_acc | input | 8 | Accumulator after the binary BCD add |
| in_cy | input | 1 | Carry flag from that add |
| in_ac | input | 1 | Half-carry flag from that add |
| out_valid | output | 1 | Result pending |
| out_ready | input | 1 | Consumer takes the result on this edge |
| out_acc | output | 8 | Adjusted accumulator |
| out_sign | output | 1 | Sign flag of the result |
| out_zero | output | 1 | Zero flag of the result |
| out_par | output | 1 | Even-parity flag of the result |
| out_ac | output | 1 | Half-carry from the correction add |
| out_cy | output | 1 | Carry after adjustment |

## Verification
The hardest case to reach from the ports is an operand offered during a stall that must be ignored. This needs a pending result, `out_ready` low and a fresh, different operand on the input, all at once. The stimulus gets there by holding `out_ready` low on a pseudo-random quarter of cycles and by driving a scrambled operand whenever `in_ready` is low. The scoreboard would catch that operand if the unit took it. Under this pressure the stimulus sweeps all 256 accumulator values against all four carry and half-carry combinations, which covers the narrow high-nibble-9 case (for example 0x9A with no flags) and the cases where the half-carry alone forces a correction.

// File: rtl/dadj_pkg.sv
package dadj_pkg;
  parameter int NIB_W = 4;
  localparam int BYTE_W = 2 * NIB_W;
  localparam int AC_IDX_W = 3;

  localparam logic [NIB_W-1:0]  DIGIT_MAX = NIB_W'(9);
  localparam logic [BYTE_W-1:0] LO_FIX    = BYTE_W'(6);
  localparam logic [BYTE_W-1:0] HI_FIX    = BYTE_W'(6) << NIB_W;
  // Half-carry true at index 2, 4, 6, 7.
  localparam logic [(1<<AC_IDX_W)-1:0] AC_TRUE_MASK = 8'b1101_0100;

  typedef struct packed {
    logic sign;
    logic zero;
    logic par;
    logic aux;
    logic cy;
  } dadj_flags_t;
endpackage

// File: rtl/dadj_corr.sv
module dadj_corr
  import dadj_pkg::*;
(
  input  logic [BYTE_W-1:0] acc,
  input  logic              cy_in,
  input  logic              ac_in,
  output logic [BYTE_W-1:0] corr,
  output logic              cy_out
);
  logic [NIB_W-1:0] lo_nib;
  logic [NIB_W-1:0] hi_nib;
  logic             lo_big;
  logic             need_lo;
  logic             need_hi;

  assign lo_nib = acc[NIB_W-1:0];
  assign hi_nib = acc[BYTE_W-1:NIB_W];
  assign lo_big = lo_nib > DIGIT_MAX;

  always_comb begin
    need_lo = ac_in | lo_big;
    need_hi = cy_in | (hi_nib > DIGIT_MAX) | ((hi_nib >= DIGIT_MAX) & lo_big);
    corr    = (need_lo ? LO_FIX : '0) | (need_hi ? HI_FIX : '0);
    cy_out  = cy_in | need_hi;
  end
endmodule

// File: rtl/dadj_adder.sv
module dadj_adder
  import dadj_pkg::*;
(
  input  logic [BYTE_W-1:0] a,
  input  logic [BYTE_W-1:0] b,
  output logic [BYTE_W-1:0] sum,
  output logic              aux
);
  logic [BYTE_W-1:0]   cin;
  logic [AC_IDX_W-1:0] ac_idx;

  assign cin[0] = 1'b0;

  for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
    assign sum[i] = a[i] ^ b[i] ^ cin[i];
    if (i < BYTE_W - 1) begin : g_carry
      assign cin[i+1] = (a[i] & b[i]) | (cin[i] & (a[i] ^ b[i]));
    end
  end

  assign ac_idx = {a[NIB_W-1], b[NIB_W-1], sum[NIB_W-1]};
  assign aux    = AC_TRUE_MASK[ac_idx];
endmodule

// File: rtl/dadj_szp.sv
module dadj_szp
  import dadj_pkg::*;
(
  input  logic [BYTE_W-1:0] value,
  output logic              sign,
  output logic              zero,
  output logic              par
);
  always_comb begin
    logic odd;
    odd = 1'b0;
    for (int i = 0; i < BYTE_W; i++) odd = odd ^ value[i];
    par  = ~odd;
    zero = (value == '0);
    sign = value[BYTE_W-1];
  end
endmodule

// File: rtl/decadj_unit.sv
module decadj_unit
  import dadj_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [BYTE_W-1:0] in_acc,
  input  logic              in_cy,
  input  logic              in_ac,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BYTE_W-1:0] out_acc,
  output logic              out_sign,
  output logic              out_zero,
  output logic              out_par,
  output logic              out_ac,
  output logic              out_cy
);
  logic [BYTE_W-1:0] corr;
  logic              cy_next;
  logic [BYTE_W-1:0] sum;
  logic              aux;
  logic              s_n, z_n, p_n;
  logic              take;
  logic [BYTE_W-1:0] res_q;
  dadj_flags_t       flg_q;

  dadj_corr u_corr (
    .acc(in_acc), .cy_in(in_cy), .ac_in(in_ac), .corr(corr), .cy_out(cy_next)
  );

  dadj_adder u_add (
    .a(in_acc), .b(corr), .sum(sum), .aux(aux)
  );

  dadj_szp u_szp (
    .value(sum), .sign(s_n), .zero(z_n), .par(p_n)
  );

  assign in_ready = ~out_valid | out_ready;
  assign take     = in_valid & in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      res_q     <= '0;
      flg_q     <= '0;
    end else begin
      if (in_ready) out_valid <= in_valid;
      if (take) begin
        res_q <= sum;
        flg_q <= '{sign: s_n, zero: z_n, par: p_n, aux: aux, cy: cy_next};
      end
    end
  end

  assign out_acc  = res_q;
  assign out_sign = flg_q.sign;
  assign out_zero = flg_q.zero;
  assign out_par  = flg_q.par;
  assign out_ac   = flg_q.aux;
  assign out_cy   = flg_q.cy;
endmodule

// File: rtl/decadj_unit_chk.sv
module decadj_unit_chk
  import dadj_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic [BYTE_W-1:0] in_acc,
  input logic              in_cy,
  input logic              in_ac,
  input logic              out_valid,
  input logic              out_ready,
  input logic [BYTE_W-1:0] out_acc,
  input logic              out_sign,
  input logic              out_zero,
  input logic              out_par,
  input logic              out_ac,
  input logic              out_cy
);
  // R8
  accept_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R8
  drain_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R9
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_acc) && $stable(out_cy)
                                   && $stable(out_ac) && $stable(out_par)));

  // R4
  sticky_cy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_cy) |=> out_cy);

  // R5
  sign_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sign == out_acc[BYTE_W-1]) && (out_zero == (out_acc == '0)));

  // R6
  parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_par == ($countones(out_acc) % 2 == 0)));

  // R1
  lo_fix_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && in_ac && !in_cy && in_acc[BYTE_W-1:NIB_W] < NIB_W'(9)
     && in_acc[NIB_W-1:0] < NIB_W'(9))
    |=> (out_acc[NIB_W-1:0] == $past(in_acc[NIB_W-1:0]) + NIB_W'(6)));
endmodule

bind decadj_unit decadj_unit_chk u_chk (.*);

// File: tb/decadj_unit_bench.sv
module decadj_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       in_valid;
  logic       in_ready;
  logic [7:0] in_acc;
  logic       in_cy;
  logic       in_ac;
  logic       out_valid;
  logic       out_ready;
  logic [7:0] out_acc;
  logic       out_sign, out_zero, out_par, out_ac, out_cy;

  always #4 clk = ~clk;

  decadj_unit u_decadj_unit (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready),
    .in_acc(in_acc), .in_cy(in_cy), .in_ac(in_ac),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_acc(out_acc), .out_sign(out_sign), .out_zero(out_zero),
    .out_par(out_par), .out_ac(out_ac), .out_cy(out_cy)
  );

  int          n_cmp = 0;
  int          n_bad = 0;
  logic [12:0] sb_q[$];
  bit          took_prev = 1'b0;
  bit          stall_prev = 1'b0;
  bit          mon_on = 1'b0;
  bit          done = 1'b0;
  logic [12:0] held;
  logic [15:0] lfsr_m = 16'hACE1;
  logic [15:0] lfsr_d = 16'h1D2B;

  function automatic logic [15:0] step(logic [15:0] x);
    return {x[14:0], x[15] ^ x[13] ^ x[12] ^ x[10]};
  endfunction

  // {result[7:0], sign, zero, par, ac, cy}
  function automatic logic [12:0] ref_model(logic [7:0] a, logic c, logic h);
    int lo, hi, corr, s;
    logic cy, aux;
    logic [7:0] r;
    lo = int'(a[3:0]);
    hi = int'(a[7:4]);
    corr = 0;
    cy = c;
    if (h || lo > 9) corr = 6;                                     // R1
    if (c || hi > 9 || (hi >= 9 && lo > 9)) begin corr += 96; cy = 1'b1; end  // R2 R4
    s = int'(a) + corr;                                            // R3
    r = s[7:0];
    aux = ((lo + (corr % 16)) > 15);                               // R7
    return {r, r[7], (r == 8'h00), ~^r, aux, cy};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(logic [7:0] a, logic c, logic h);
    forever begin
      @(negedge clk);
      #1;
      lfsr_d = step(lfsr_d);
      if (lfsr_d[2:0] == 3'd0) begin
        in_valid = 1'b0;
        took_prev = 1'b0;
      end else if (in_ready) begin
        in_valid = 1'b1;
        in_acc = a; in_cy = c; in_ac = h;
        sb_q.push_back(ref_model(a, c, h));
        took_prev = 1'b1;
        break;
      end else begin
        // R9: scrambled operand offered during a stall must be ignored
        in_valid = 1'b1;
        in_acc = a ^ 8'h5A; in_cy = ~c; in_ac = ~h;
        took_prev = 1'b0;
      end
    end
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (took_prev) chk("R8 out_valid after accept", int'(out_valid), 1);
      if (stall_prev) begin
        chk("R9 valid held", int'(out_valid), 1);
        chk("R9 result held", int'({out_acc, out_sign, out_zero, out_par, out_ac, out_cy}), int'(held));
      end
      lfsr_m = step(lfsr_m);
      out_ready = lfsr_m[0] | lfsr_m[1];
      if (out_valid && out_ready) begin
        if (sb_q.size() == 0) begin
          chk("R8 unexpected output", 1, 0);
        end else begin
          logic [12:0] e;
          e = sb_q.pop_front();
          chk("R1 R2 R3 out_acc", int'(out_acc), int'(e[12:5]));
          chk("R5 out_sign", int'(out_sign), int'(e[4]));
          chk("R5 out_zero", int'(out_zero), int'(e[3]));
          chk("R6 out_par", int'(out_par), int'(e[2]));
          chk("R7 out_ac", int'(out_ac), int'(e[1]));
          chk("R4 out_cy", int'(out_cy), int'(e[0]));
        end
      end
      stall_prev = out_valid && !out_ready;
      held = {out_acc, out_sign, out_zero, out_par, out_ac, out_cy};
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    in_valid = 1'b0;
    in_acc = 8'h00; in_cy = 1'b0; in_ac = 1'b0;
    out_ready = 1'b0;
    repeat (3) @(negedge clk);
    chk("R10 out_valid in reset", int'(out_valid), 0);
    chk("R10 in_ready in reset", int'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    mon_on = 1'b1;
    for (int i = 0; i < 1024; i++) begin
      send(i[7:0], i[8], i[9]);
    end
    @(negedge clk);
    #1;
    in_valid = 1'b0;
    took_prev = 1'b0;
    while (sb_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    #2;
    chk("R8 idle after drain", int'(out_valid), 0);
    chk("R8 queue empty", sb_q.size(), 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule